// File: doc/BRIEF.md
# Datapath Flush and Power-Down Sequencer

This block sequences the digital datapath of a transmit converter around its transmit-enable input. While the enable is active, samples pass through the interpolation chain and the digital engine is clocked. When the enable goes inactive, the block drives a zero-insert strobe. This flushes the interpolation filters with zeros for a number of reference cycles that matches the selected interpolation depth. Depending on a mode bit, it then either keeps inserting zeros with the clock running, or gates the digital-engine clock off. When the enable returns, the clock is restored first and zero insertion is released one cycle later.

Configuration bits from a register port select global power-down, automatic digital power-down and enable polarity. They also select a sleep mode that turns off only the output stage. Global power-down switches off the reference, the output stage and the digital engine together. The analog circuits are represented only by their enable outputs. The transmit-enable input is asynchronous and passes through a synchroniser into the reference clock domain before use.

The controller has six named states. ST_RUN passes data. ST_FLUSH inserts zeros while the timer runs. ST_ZERO_HOLD keeps inserting zeros with the clock running. ST_HALTED gates the digital clock off. ST_WAKE restores the clock while zeros are still inserted. ST_GLOBAL_PD switches everything off.

Global power-down has priority and moves any state to ST_GLOBAL_PD. Clearing it moves ST_GLOBAL_PD to ST_WAKE. The other transitions are:
- ST_RUN moves to ST_FLUSH when the enable goes inactive.
- ST_FLUSH moves to ST_WAKE when the enable becomes active. When the timer ends, it moves to ST_HALTED if auto power-down is set, and to ST_ZERO_HOLD if not.
- ST_ZERO_HOLD moves to ST_WAKE when the enable becomes active, and to ST_HALTED when auto power-down is set.
- ST_HALTED moves to ST_WAKE when the enable becomes active.
- ST_WAKE moves to ST_RUN if the enable is active, and otherwise to ST_FLUSH, which reloads the timer.

Reset enters ST_ZERO_HOLD.

Top module: `dp_flush_seq`

## Requirements
- R1: A change on tx_en_in reaches the outputs on the third rising clk_ref edge after it is applied, and not before.
- R2: With cfg_en_inv=1 the enable is active when tx_en_in is 0. A change of cfg_en_inv takes effect on the next rising edge.
- R3: While active and running, the outputs {zero_insert, dig_clk_en, ref_pwr_en, out_pwr_en} are 0111. An inactive enable makes them 1111, which starts the flush.
- R4: The flush lasts exactly 32, 64 or 128 clk_ref cycles when interp_sel is 0 (2x), 1 (4x), or 2 or 3 (8x). The selection is taken when the flush starts.
- R5: With cfg_auto_pd=1, dig_clk_en falls when the flush ends, and ref_pwr_en and out_pwr_en stay 1.
- R6: With cfg_auto_pd=0, zero insertion continues with dig_clk_en=1 for as long as the enable stays inactive.
- R7: If the enable becomes active before the flush ends, the flush is abandoned, and the next inactive period runs a full flush length.
- R8: On reactivation, dig_clk_en is 1 while zero_insert is still 1 for one cycle. zero_insert falls on the following edge.
- R9: cfg_global_pd=1 gives outputs 1000 from the next edge. Clearing it gives one wake cycle (1111) and then normal operation.
- R10: cfg_sleep=1 forces out_pwr_en to 0 immediately and leaves ref_pwr_en and dig_clk_en unchanged.
- R11: During reset the outputs are 1111 (zeros inserted, clock running, analog enabled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en_in | input | 1 | Asynchronous transmit enable |
| cfg_global_pd | input | 1 | Global power-down bit |
| cfg_auto_pd | input | 1 | Automatic digital power-down after flush |
| cfg_en_inv | input | 1 | Invert the transmit-enable polarity |
| cfg_sleep | input | 1 | Output-stage sleep |
| interp_sel | input | 2 | Interpolation depth: 0=2x, 1=4x, 2/3=8x |
| zero_insert | output | 1 | Force zeros into the interpolation datapath |
| dig_clk_en | output | 1 | Digital-engine clock enable |
| ref_pwr_en | output | 1 | Reference power enable |
| out_pwr_en | output | 1 | Output-stage power enable |

## Verification
The assertions assume that the configuration bits and interp_sel are already synchronous to clk_ref, because the block uses them without a synchroniser. The stimulus therefore changes every input only on the falling clock edge. The interpolation setting and the auto power-down bit are changed only while the controller sits in ST_RUN, so a flush never sees them change midway. The properties on the wake ordering and the clock gating also take for granted that tx_en_in is held steady during reset.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_FLUSH     = 3'd1,
        ST_ZERO_HOLD = 3'd2,
        ST_HALTED    = 3'd3,
        ST_WAKE      = 3'd4,
        ST_GLOBAL_PD = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        INTERP_2X     = 2'd0,
        INTERP_4X     = 2'd1,
        INTERP_8X     = 2'd2,
        INTERP_8X_ALT = 2'd3
    } interp_e;

endpackage

// File: rtl/txen_sync.sv
module txen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    input  logic invert,
    output logic active_o
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    // polarity applied after resynchronisation so an invert change acts at once
    assign active_o = chain[STAGES-1] ^ invert;

endmodule

// File: rtl/flush_timer.sv
module flush_timer
    import dfs_pkg::*;
#(
    parameter int LEN_2X = 32,
    parameter int LEN_4X = 64,
    parameter int LEN_8X = 128
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load,
    input  logic    run,
    input  interp_e sel,
    output logic    done
);
    localparam int CW = $clog2(LEN_8X + 1);

    logic [CW-1:0] len;
    logic [CW-1:0] cnt;

    always_comb begin
        unique case (sel)
            INTERP_2X:     len = CW'(LEN_2X);
            INTERP_4X:     len = CW'(LEN_4X);
            INTERP_8X:     len = CW'(LEN_8X);
            INTERP_8X_ALT: len = CW'(LEN_8X);
            default:       len = CW'(LEN_8X);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len - CW'(1);
        end else if (run && cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign done = (cnt == '0);

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(LEN_8X));

    // R7
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !done);

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import dfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active,
    input  logic global_pd,
    input  logic auto_pd,
    input  logic sleep,
    input  logic flush_done,
    output logic timer_load,
    output logic timer_run,
    output logic zero_insert,
    output logic dig_clk_en,
    output logic ref_pwr_en,
    output logic out_pwr_en
);
    seq_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        if (global_pd) begin
            state_nx = ST_GLOBAL_PD;
        end else begin
            unique case (state)
                ST_RUN:       if (!tx_active) state_nx = ST_FLUSH;
                ST_FLUSH: begin
                    if (tx_active)       state_nx = ST_WAKE;
                    else if (flush_done) state_nx = auto_pd ? ST_HALTED : ST_ZERO_HOLD;
                end
                ST_ZERO_HOLD: begin
                    if (tx_active)    state_nx = ST_WAKE;
                    else if (auto_pd) state_nx = ST_HALTED;
                end
                ST_HALTED:    if (tx_active) state_nx = ST_WAKE;
                ST_WAKE:      state_nx = tx_active ? ST_RUN : ST_FLUSH;
                ST_GLOBAL_PD: state_nx = ST_WAKE;
                default:      state_nx = ST_ZERO_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ZERO_HOLD;
        else        state <= state_nx;
    end

    assign timer_load = (state_nx == ST_FLUSH) && (state != ST_FLUSH);
    assign timer_run  = (state == ST_FLUSH);

    always_comb begin
        zero_insert = 1'b1;
        dig_clk_en  = 1'b1;
        ref_pwr_en  = 1'b1;
        unique case (state)
            ST_RUN:       zero_insert = 1'b0;
            ST_FLUSH:     zero_insert = 1'b1;
            ST_ZERO_HOLD: zero_insert = 1'b1;
            ST_HALTED:    dig_clk_en  = 1'b0;
            ST_WAKE:      zero_insert = 1'b1;
            ST_GLOBAL_PD: begin
                dig_clk_en = 1'b0;
                ref_pwr_en = 1'b0;
            end
            default:      zero_insert = 1'b1;
        endcase
        out_pwr_en = ref_pwr_en && !sleep;
    end

    // R8
    wake_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(zero_insert) |-> (dig_clk_en && $past(dig_clk_en)));

    // R5
    gate_after_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dig_clk_en) && ref_pwr_en) |-> $past(zero_insert));

    // R9
    gpd_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        global_pd |=> (!ref_pwr_en && !dig_clk_en && !out_pwr_en && zero_insert));

    // R4
    flush_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH && flush_done && !tx_active && !global_pd) |=> (state != ST_FLUSH));

    // R6
    hold_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ZERO_HOLD && !auto_pd && !global_pd) |=> dig_clk_en);

endmodule

// File: rtl/dp_flush_seq.sv
module dp_flush_seq
    import dfs_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int FLUSH_LEN_2X = 32,
    parameter int FLUSH_LEN_4X = 64,
    parameter int FLUSH_LEN_8X = 128
) (
    input  logic       clk_ref,
    input  logic       rst_n,
    input  logic       tx_en_in,
    input  logic       cfg_global_pd,
    input  logic       cfg_auto_pd,
    input  logic       cfg_en_inv,
    input  logic       cfg_sleep,
    input  logic [1:0] interp_sel,
    output logic       zero_insert,
    output logic       dig_clk_en,
    output logic       ref_pwr_en,
    output logic       out_pwr_en
);
    logic tx_active;
    logic timer_load;
    logic timer_run;
    logic flush_done;

    txen_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .async_in (tx_en_in),
        .invert   (cfg_en_inv),
        .active_o (tx_active)
    );

    flush_timer #(
        .LEN_2X (FLUSH_LEN_2X),
        .LEN_4X (FLUSH_LEN_4X),
        .LEN_8X (FLUSH_LEN_8X)
    ) u_timer (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .load  (timer_load),
        .run   (timer_run),
        .sel   (interp_e'(interp_sel)),
        .done  (flush_done)
    );

    seq_fsm u_fsm (
        .clk         (clk_ref),
        .rst_n       (rst_n),
        .tx_active   (tx_active),
        .global_pd   (cfg_global_pd),
        .auto_pd     (cfg_auto_pd),
        .sleep       (cfg_sleep),
        .flush_done  (flush_done),
        .timer_load  (timer_load),
        .timer_run   (timer_run),
        .zero_insert (zero_insert),
        .dig_clk_en  (dig_clk_en),
        .ref_pwr_en  (ref_pwr_en),
        .out_pwr_en  (out_pwr_en)
    );

    // R10
    sleep_ref_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (cfg_sleep && !cfg_global_pd && !$past(cfg_global_pd)) |-> (ref_pwr_en && !out_pwr_en));

endmodule

// File: tb/tb_dp_flush_seq.sv
module tb_dp_flush_seq;

    logic       clk_ref = 1'b0;
    logic       rst_n;
    logic       tx_en_in;
    logic       cfg_global_pd;
    logic       cfg_auto_pd;
    logic       cfg_en_inv;
    logic       cfg_sleep;
    logic [1:0] interp_sel;
    logic       zero_insert, dig_clk_en, ref_pwr_en, out_pwr_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [3:0] O_RUN  = 4'b0111;
    localparam logic [3:0] O_ZERO = 4'b1111;
    localparam logic [3:0] O_HALT = 4'b1011;
    localparam logic [3:0] O_GPD  = 4'b1000;

    always #4 clk_ref = ~clk_ref;

    dp_flush_seq dut (
        .clk_ref       (clk_ref),
        .rst_n         (rst_n),
        .tx_en_in      (tx_en_in),
        .cfg_global_pd (cfg_global_pd),
        .cfg_auto_pd   (cfg_auto_pd),
        .cfg_en_inv    (cfg_en_inv),
        .cfg_sleep     (cfg_sleep),
        .interp_sel    (interp_sel),
        .zero_insert   (zero_insert),
        .dig_clk_en    (dig_clk_en),
        .ref_pwr_en    (ref_pwr_en),
        .out_pwr_en    (out_pwr_en)
    );

    function automatic logic [3:0] outs();
        return {zero_insert, dig_clk_en, ref_pwr_en, out_pwr_en};
    endfunction

    task automatic check(input string req, input logic [3:0] exp);
        n_chk++;
        if (outs() !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs actual %b expected %b at %0t", req, outs(), exp, $time);
        end
    endtask

    task automatic edge_n(input int n);
        repeat (n) @(posedge clk_ref);
        #1;
    endtask

    // enable back to active from a non-running state: wake cycle then run
    task automatic wake_from(input string req, input logic [3:0] idle_exp);
        @(negedge clk_ref);
        tx_en_in = 1'b1;
        edge_n(2);
        check(req, idle_exp);         // R1 not yet visible
        edge_n(1);
        check("R8 wake", O_ZERO);     // R8 clock on, zeros still forced
        edge_n(1);
        check("R8 release", O_RUN);   // R8 zeros released
    endtask

    task automatic t_reset();
        rst_n = 1'b0; tx_en_in = 1'b0; cfg_global_pd = 1'b0; cfg_auto_pd = 1'b0;
        cfg_en_inv = 1'b0; cfg_sleep = 1'b0; interp_sel = 2'd0;
        edge_n(3);
        check("R11 reset", O_ZERO);
        @(negedge clk_ref);
        rst_n = 1'b1;
        edge_n(2);
        check("R11 after reset", O_ZERO);
        wake_from("R1 before sync", O_ZERO);
    endtask

    task automatic t_flush(input logic [1:0] sel, input int len, input logic auto_pd);
        @(negedge clk_ref);
        interp_sel  = sel;
        cfg_auto_pd = auto_pd;
        tx_en_in    = 1'b0;
        edge_n(2);
        check("R1 latency", O_RUN);
        edge_n(1);
        check("R3 flush start", O_ZERO);
        edge_n(len - 1);
        check("R4 flush length", O_ZERO);
        edge_n(1);
        if (auto_pd) begin
            check("R5 auto power-down", O_HALT);
            wake_from("R5 halted", O_HALT);
        end else begin
            check("R6 zero hold", O_ZERO);
            edge_n(200);
            check("R6 long hold", O_ZERO);
            wake_from("R6 hold", O_ZERO);
        end
    endtask

    task automatic t_restart();
        @(negedge clk_ref);
        interp_sel = 2'd0; cfg_auto_pd = 1'b1; tx_en_in = 1'b0;
        edge_n(3);
        check("R7 flush", O_ZERO);
        edge_n(10);
        wake_from("R7 abort", O_ZERO);
        @(negedge clk_ref);
        tx_en_in = 1'b0;
        edge_n(3);
        check("R7 second flush", O_ZERO);
        edge_n(31);
        check("R7 full length", O_ZERO);
        edge_n(1);
        check("R7 halted", O_HALT);
        wake_from("R7 halted", O_HALT);
    endtask

    task automatic t_invert();
        @(negedge clk_ref);
        cfg_auto_pd = 1'b0;
        cfg_en_inv  = 1'b1;
        edge_n(1);
        check("R2 invert immediate", O_ZERO);
        @(negedge clk_ref);
        tx_en_in = 1'b0;
        edge_n(3);
        check("R2 low is active wake", O_ZERO);
        edge_n(1);
        check("R2 low is active", O_RUN);
        @(negedge clk_ref);
        tx_en_in = 1'b1;
        edge_n(4);
        check("R2 high is inactive", O_ZERO);
        @(negedge clk_ref);
        cfg_en_inv = 1'b0;
        edge_n(3);
        check("R2 invert cleared", O_RUN);
    endtask

    task automatic t_gpd();
        @(negedge clk_ref);
        cfg_global_pd = 1'b1;
        edge_n(1);
        check("R9 global off", O_GPD);
        edge_n(5);
        check("R9 global held", O_GPD);
        @(negedge clk_ref);
        cfg_global_pd = 1'b0;
        edge_n(1);
        check("R9 wake", O_ZERO);
        edge_n(1);
        check("R9 resume", O_RUN);
    endtask

    task automatic t_sleep();
        @(negedge clk_ref);
        cfg_sleep = 1'b1;
        #1;
        check("R10 sleep immediate", 4'b0110);
        edge_n(3);
        check("R10 sleep held", 4'b0110);
        @(negedge clk_ref);
        cfg_sleep = 1'b0;
        #1;
        check("R10 sleep cleared", O_RUN);
    endtask

    initial begin
        t_reset();
        t_flush(2'd0, 32, 1'b1);
        t_flush(2'd1, 64, 1'b1);
        t_flush(2'd2, 128, 1'b0);
        t_flush(2'd3, 128, 1'b1);
        t_restart();
        t_invert();
        t_gpd();
        t_sleep();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule